// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block keeps the transfer address and transfer length for a small set of DMA channels and makes them available through a narrow byte-wide port. Every channel holds a programmed start address, a programmed length, a working address latched from the start address, and a progress value. The progress value comes from the transfer engine and gives the number of units moved so far. A programmed word is 16 bits wide and is written as two byte accesses. One byte-order toggle, shared by every channel, decides whether an access reaches the low half or the high half.

A three-bit port index selects the target. The upper bits pick the channel and the lowest bit picks either the address or the length. A read does not return the stored words. It returns values derived from them: the working address plus the progress, or the programmed length minus the progress. Host software can therefore watch a transfer as it runs. Writing the high half of either word restarts the channel's bookkeeping. A parameter selects a word-wide variant, in which the programmed values count 16-bit units and so are doubled before use, and read-back is halved again before the byte is picked.

At most one of the read and write strobes is raised in any cycle.

Top module: `dmaregs_bank`

## Requirements
- R1: After reset, the byte toggle is 0, all stored words and progress values are zero, and a read of any register returns 0x00.
- R2: Bits 2:1 of `port_idx` select the channel and bit 0 selects the register: 0 is the address, 1 is the length.
- R3: Every read or write access uses the current value of the shared byte toggle and then inverts it, whichever channel the access targets. With no access and no clear, the toggle holds.
- R4: A write while the toggle is 0 replaces bits 7:0 of the selected programmed word and leaves the channel's working address and progress unchanged.
- R5: A write while the toggle is 1 replaces bits 15:8 of the selected programmed word. It also loads the channel's working address from its (updated) programmed address and clears its progress to zero.
- R6: A read of the address register yields the working address plus the progress, modulo the value width.
- R7: A read of the length register yields the programmed length minus the progress, modulo the value width, so a progress larger than the length wraps.
- R8: A read returns bits 7:0 of the value while the toggle is 0 and bits 15:8 while it is 1.
- R9: `ptr_clr` or reset forces the toggle to 0 in the next cycle, even when an access in the same cycle would invert it. Such an access still uses the toggle value it sees.
- R10: A `xfer_done` pulse loads the progress of channel `xfer_chan` with `xfer_units`. When a high-byte write to the same channel falls in the same cycle, the write's clear of the progress wins.
- R11: With `WIDE_SHIFT` = 1, the programmed address and length are shifted left by one before use, and a read takes its byte from the value after a right shift by one.
- R12: While `port_rd` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_wr | input | 1 | Byte write strobe |
| port_rd | input | 1 | Byte read strobe |
| port_idx | input | 3 | Register index: channel in bits 2:1, register select in bit 0 |
| wdata | input | 8 | Write byte |
| ptr_clr | input | 1 | Clears the shared byte toggle |
| xfer_done | input | 1 | Progress update strobe from the transfer engine |
| xfer_chan | input | 2 | Channel of the progress update |
| xfer_units | input | 16 | Units moved on that channel |
| rdata | output | 8 | Read byte, valid in the cycle `port_rd` is high |

## Verification
Directed sequences first program and read back a single channel. They then interleave accesses across channels, so a toggle kept per channel would give a different byte than the shared one. A low-byte write followed by a read distinguishes a low write from a reload. Progress values larger than the length, and addresses close to 0xFFFF, expose wrap handling. A progress update that lands in the same cycle as a high-byte write shows which of the two wins, and a clear that lands in the same cycle as an access shows clear priority. A long run of pseudo-random accesses, clears and progress updates then drives the byte-wide instance and the word-wide instance side by side. Both are compared every cycle against a behavioural model.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;

   typedef enum logic {
      SEL_ADDR  = 1'b0,
      SEL_COUNT = 1'b1
   } reg_sel_e;

   typedef enum logic {
      PTR_LO = 1'b0,
      PTR_HI = 1'b1
   } byte_ptr_e;

endpackage

// File: rtl/dmaregs_ptr.sv
module dmaregs_ptr
   import dmaregs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      access,
   input  logic      clear,
   output byte_ptr_e ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= PTR_LO;
      else if (clear)
         ptr <= PTR_LO;
      else if (access)
         ptr <= (ptr == PTR_LO) ? PTR_HI : PTR_LO;
   end

   AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      access && !clear |=> ptr != $past(ptr)); // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !access && !clear |=> $stable(ptr)); // R3
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ptr == PTR_LO); // R9

endmodule

// File: rtl/dmaregs_chan.sv
module dmaregs_chan
   import dmaregs_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int SHIFT  = 0,
   localparam int VAL_W = WORD_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          wr_sel,
   input  byte_ptr_e         wr_ptr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              done_en,
   input  logic [WORD_W-1:0] done_units,
   output logic [VAL_W-1:0]  addr_view,
   output logic [VAL_W-1:0]  cnt_view
);

   logic [WORD_W-1:0] base_addr, base_cnt;
   logic [WORD_W-1:0] base_addr_nx, base_cnt_nx;
   logic [VAL_W-1:0]  cur_addr;
   logic [WORD_W-1:0] progress;
   logic [VAL_W-1:0]  scaled_addr_nx, scaled_cnt;
   logic              reload;

   function automatic logic [WORD_W-1:0] put_byte(
      input logic [WORD_W-1:0] old,
      input logic [BYTE_W-1:0] b,
      input byte_ptr_e         p);
      logic [WORD_W-1:0] r;
      r = old;
      if (p == PTR_HI) r[WORD_W-1:BYTE_W] = b;
      else             r[BYTE_W-1:0]      = b;
      return r;
   endfunction

   always_comb begin
      base_addr_nx = base_addr;
      base_cnt_nx  = base_cnt;
      if (wr_en) begin
         if (wr_sel == SEL_COUNT) base_cnt_nx  = put_byte(base_cnt, wdata, wr_ptr);
         else                     base_addr_nx = put_byte(base_addr, wdata, wr_ptr);
      end
   end

   assign reload = wr_en && (wr_ptr == PTR_HI);

   if (SHIFT == 1) begin : g_word
      assign scaled_addr_nx = {base_addr_nx, 1'b0};
      assign scaled_cnt     = {base_cnt, 1'b0};
   end else begin : g_byte
      assign scaled_addr_nx = base_addr_nx;
      assign scaled_cnt     = base_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         progress  <= '0;
      end else begin
         base_addr <= base_addr_nx;
         base_cnt  <= base_cnt_nx;
         if (reload) begin
            cur_addr <= scaled_addr_nx;
            progress <= '0;
         end else if (done_en) begin
            progress <= done_units;
         end
      end
   end

   assign addr_view = cur_addr + VAL_W'(progress);
   assign cnt_view  = scaled_cnt - VAL_W'(progress);

   AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> progress == '0); // R5
   AST_RELOAD_TRACKS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> cur_addr == (VAL_W'(base_addr) << SHIFT)); // R5
   AST_LOW_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_ptr == PTR_LO |=> $stable(cur_addr)); // R4
   AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      done_en && !reload |=> progress == $past(done_units)); // R10

endmodule

// File: rtl/dmaregs_rdmux.sv
module dmaregs_rdmux
   import dmaregs_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int SHIFT  = 0,
   localparam int VAL_W = WORD_W + SHIFT,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0][VAL_W-1:0] addr_views,
   input  logic [NUM_CH-1:0][VAL_W-1:0] cnt_views,
   input  logic                         rd_en,
   input  logic [CH_W-1:0]              chan,
   input  reg_sel_e                     sel,
   input  byte_ptr_e                    ptr,
   output logic [BYTE_W-1:0]            rdata
);

   logic [VAL_W-1:0]  val;
   logic [WORD_W-1:0] aligned;

   assign val = (sel == SEL_COUNT) ? cnt_views[chan] : addr_views[chan];

   if (SHIFT == 1) begin : g_word
      assign aligned = val[VAL_W-1:1];
   end else begin : g_byte
      assign aligned = val;
   end

   always_comb begin
      rdata = '0;
      if (rd_en)
         rdata = (ptr == PTR_HI) ? aligned[WORD_W-1:BYTE_W] : aligned[BYTE_W-1:0];
   end

endmodule

// File: rtl/dmaregs_bank.sv
module dmaregs_bank
   import dmaregs_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int WORD_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int WIDE_SHIFT = 0,
   localparam int CH_W      = $clog2(NUM_CH),
   localparam int IDX_W     = CH_W + 1,
   localparam int VAL_W     = WORD_W + WIDE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_wr,
   input  logic              port_rd,
   input  logic [IDX_W-1:0]  port_idx,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              ptr_clr,
   input  logic              xfer_done,
   input  logic [CH_W-1:0]   xfer_chan,
   input  logic [WORD_W-1:0] xfer_units,
   output logic [BYTE_W-1:0] rdata
);

   if (WORD_W != 2 * BYTE_W) begin : g_bad_width
      $error("dmaregs_bank: WORD_W must be twice BYTE_W");
   end
   if (WIDE_SHIFT != 0 && WIDE_SHIFT != 1) begin : g_bad_shift
      $error("dmaregs_bank: WIDE_SHIFT must be 0 or 1");
   end
   if ((1 << CH_W) != NUM_CH) begin : g_bad_chan
      $error("dmaregs_bank: NUM_CH must be a power of two");
   end

   byte_ptr_e                    ptr;
   logic [CH_W-1:0]              chan;
   reg_sel_e                     sel;
   logic [NUM_CH-1:0][VAL_W-1:0] addr_views;
   logic [NUM_CH-1:0][VAL_W-1:0] cnt_views;

   assign chan = port_idx[IDX_W-1:1];
   assign sel  = reg_sel_e'(port_idx[0]);

   dmaregs_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (port_wr | port_rd),
      .clear  (ptr_clr),
      .ptr    (ptr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      dmaregs_chan #(
         .WORD_W (WORD_W),
         .BYTE_W (BYTE_W),
         .SHIFT  (WIDE_SHIFT)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (port_wr && chan == CH_W'(i)),
         .wr_sel     (sel),
         .wr_ptr     (ptr),
         .wdata      (wdata),
         .done_en    (xfer_done && xfer_chan == CH_W'(i)),
         .done_units (xfer_units),
         .addr_view  (addr_views[i]),
         .cnt_view   (cnt_views[i])
      );
   end

   dmaregs_rdmux #(
      .NUM_CH (NUM_CH),
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W),
      .SHIFT  (WIDE_SHIFT)
   ) u_rdmux (
      .addr_views (addr_views),
      .cnt_views  (cnt_views),
      .rd_en      (port_rd),
      .chan       (chan),
      .sel        (sel),
      .ptr        (ptr),
      .rdata      (rdata)
   );

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !port_rd |-> rdata == '0); // R12

endmodule

// File: tb/dmaregs_bank_tb.sv
`timescale 1ns/1ps
module dmaregs_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_wr = 1'b0, port_rd = 1'b0, ptr_clr = 1'b0, xfer_done = 1'b0;
   logic [2:0]  port_idx = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  xfer_chan = '0;
   logic [15:0] xfer_units = '0;
   logic [7:0]  rdata, rdata_w;

   int n_chk = 0, n_fail = 0;
   string scen_tag = "";

   // reference model state
   int base_a [4], base_c [4], cur_base [4], prog [4];
   int ptr_m;

   always #5 clk = ~clk;

   dmaregs_bank #(.WIDE_SHIFT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
      .port_idx(port_idx), .wdata(wdata), .ptr_clr(ptr_clr),
      .xfer_done(xfer_done), .xfer_chan(xfer_chan), .xfer_units(xfer_units),
      .rdata(rdata));

   dmaregs_bank #(.WIDE_SHIFT(1)) dut_w_i (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
      .port_idx(port_idx), .wdata(wdata), .ptr_clr(ptr_clr),
      .xfer_done(xfer_done), .xfer_chan(xfer_chan), .xfer_units(xfer_units),
      .rdata(rdata_w));

   function automatic int model_read(input int sh);
      int ch, val, mask;
      if (!port_rd) return 0;
      ch   = int'(port_idx[2:1]);
      mask = (1 << (16 + sh)) - 1;
      if (port_idx[0]) val = (base_c[ch] << sh) - prog[ch];   // length view
      else             val = (cur_base[ch] << sh) + prog[ch]; // address view
      val = val & mask;
      return (val >> (sh + 8 * ptr_m)) & 255;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: idx=%0d rdata=0x%02h expected 0x%02h", tag, port_idx, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         base_a[i] = 0; base_c[i] = 0; cur_base[i] = 0; prog[i] = 0;
      end
      ptr_m = 0;
   endtask

   task automatic model_step();
      int ch;
      bit reload;
      ch = int'(port_idx[2:1]);
      reload = port_wr && ptr_m == 1;
      if (port_wr) begin
         if (port_idx[0]) begin
            if (ptr_m == 1) base_c[ch] = (base_c[ch] & 'h00FF) | (int'(wdata) << 8);
            else            base_c[ch] = (base_c[ch] & 'hFF00) | int'(wdata);
         end else begin
            if (ptr_m == 1) base_a[ch] = (base_a[ch] & 'h00FF) | (int'(wdata) << 8);
            else            base_a[ch] = (base_a[ch] & 'hFF00) | int'(wdata);
         end
         if (reload) begin
            cur_base[ch] = base_a[ch];
            prog[ch] = 0;
         end
      end
      if (xfer_done && !(reload && int'(xfer_chan) == ch))
         prog[int'(xfer_chan)] = int'(xfer_units);
      if (ptr_clr) ptr_m = 0;
      else if (port_wr || port_rd) ptr_m = ptr_m ^ 1;
   endtask

   // one cycle: drive at negedge, compare before posedge, update model after
   task automatic cyc(input logic wr, input logic rd, input logic [2:0] idx,
                      input logic [7:0] d, input logic clr, input logic dn,
                      input logic [1:0] xc, input logic [15:0] xu);
      string tag;
      port_wr = wr; port_rd = rd; port_idx = idx; wdata = d;
      ptr_clr = clr; xfer_done = dn; xfer_chan = xc; xfer_units = xu;
      #1;
      if (scen_tag != "")   tag = scen_tag;
      else if (!rd)         tag = "R12";
      else if (idx[0])      tag = "R7";
      else                  tag = "R6";
      check(tag, int'(rdata), model_read(0));
      check((scen_tag != "") ? scen_tag : "R11", int'(rdata_w), model_read(1));
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic wr8(input logic [2:0] idx, input logic [7:0] d);
      cyc(1, 0, idx, d, 0, 0, 0, 0);
   endtask
   task automatic rd8(input logic [2:0] idx);
      cyc(0, 1, idx, 0, 0, 0, 0, 0);
   endtask
   task automatic done(input logic [1:0] c, input logic [15:0] u);
      cyc(0, 0, 0, 0, 0, 1, c, u);
   endtask
   task automatic clr();
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state on every register, both bytes
      scen_tag = "R1";
      for (int i = 0; i < 8; i++) begin rd8(3'(i)); rd8(3'(i)); end

      // R2 / R5: program channel 2 address 0x1234 and length 0x0010
      scen_tag = "R5";
      wr8(3'd4, 8'h34); wr8(3'd4, 8'h12);
      wr8(3'd5, 8'h10); wr8(3'd5, 8'h00);
      scen_tag = "R2";
      for (int i = 0; i < 8; i++) rd8(3'(i));

      // R4: low write alone does not move the working address
      scen_tag = "R4";
      wr8(3'd4, 8'h99); clr(); rd8(3'd4); rd8(3'd4);

      // R10: progress update, then reads of both views
      scen_tag = "R10";
      done(2'd2, 16'd7);
      rd8(3'd4); rd8(3'd4); rd8(3'd5); rd8(3'd5);
      // R10: progress larger than length wraps the length view (R7)
      done(2'd2, 16'h0020);
      rd8(3'd5); rd8(3'd5);
      // R10: high write and progress update collide on one channel
      wr8(3'd5, 8'h40);
      cyc(1, 0, 3'd5, 8'h01, 0, 1, 2'd2, 16'h0055);
      rd8(3'd5); rd8(3'd5); rd8(3'd4); rd8(3'd4);

      // R3: toggle is shared across channels
      scen_tag = "R3";
      wr8(3'd2, 8'hAB); rd8(3'd6); rd8(3'd2); rd8(3'd2);

      // R9: clear in the same cycle as an access
      scen_tag = "R9";
      rd8(3'd4);
      cyc(0, 1, 3'd4, 0, 1, 0, 0, 0);
      rd8(3'd4); rd8(3'd4);

      // R6 / R8: address wrap near top of range
      scen_tag = "R8";
      clr();
      wr8(3'd0, 8'hFE); wr8(3'd0, 8'hFF);
      done(2'd0, 16'd5);
      rd8(3'd0); rd8(3'd0);

      // pseudo-random traffic on all features
      scen_tag = "";
      for (int i = 0; i < 2000; i++) begin
         int r;
         logic wr, rd;
         r  = $urandom;
         wr = (r % 4) == 0;
         rd = !wr && ((r % 4) != 3);
         cyc(wr, rd, 3'($urandom), 8'($urandom), ($urandom % 16) == 0,
             ($urandom % 5) == 0, 2'($urandom), 16'($urandom));
      end

      summary();
      $finish;
   end

endmodule